// File: doc/BRIEF.md
# Inbound Address Translation Unit

This block maps the addresses of incoming memory requests onto local system addresses. It holds five programmable inbound regions. A region either binds to one BAR, in which case the BAR's static mask decides how much of the incoming address is kept, or it covers a fixed 16 MiB window that starts at a programmed address. Each request carries a 64-bit address and the number of the BAR it hit. The block answers one cycle later with the translated address, a hit flag and the number of the region that matched.

Software programs the regions indirectly through a write-only register bus. A viewport register picks the region. Writes to the target, type, control and start registers then go to that region. Requests enter through a valid/ready port and results leave through another. A two-state output stage lies between them. In `ST_EMPTY` the stage holds nothing and `req_ready` is high. On the `LOAD` transition (a request is presented) it moves to `ST_FULL`. In `ST_FULL` the result is shown. The stage returns to `ST_EMPTY` on the `DRAIN` transition (`rsp_ready` high with no new request). It stays in `ST_FULL` on `HOLD` (`rsp_ready` low) or on `REFILL` (`rsp_ready` high and a new request accepted in the same cycle).

Top module: `inb_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, the viewport is 0 and every region is disabled. A request made before any programming returns its own address with `rsp_hit` 0.
- R2: `cfg_addr` selects the register: 0 viewport, 1 target bits [31:0], 2 target bits [63:32], 3 type word, 4 mode word, 5 start bits [31:0], 6 start bits [63:32]. Writes to codes 1 to 6 go to the region the viewport names. A viewport write of 5 or more is ignored, and the previous selection is kept.
- R3: In the mode word, bit 31 enables the region and bit 30 set selects BAR match (clear selects address match). Bits [10:8] hold the BAR number. The type word bits [4:0] hold the region type, and 0 means memory.
- R4: An enabled memory region in BAR match hits when `req_bar` equals its BAR number. With mask M of that BAR, the result is {target[63:32], (target[31:0] & M) | (req_addr[31:0] & ~M)}.
- R5: An enabled memory region in address match hits when start ≤ `req_addr` ≤ start + 0xFF_FFFF. The result is target + (`req_addr` − start).
- R6: When several regions hit, the lowest-numbered one supplies the result, and its number appears on `rsp_region`.
- R7: With no hit, `rsp_addr` equals `req_addr`, `rsp_hit` is 0 and `rsp_region` is 0.
- R8: A request accepted on one clock (`req_valid` and `req_ready` high) shows its result with `rsp_valid` high after that clock. `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result holds unchanged.
- R9: A region whose enable bit is 0, or whose type is not 0, never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| bar_mask | input | NUM_BARS*32 | Static BAR masks, BAR b in bits [32b+31:32b] |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | Incoming request address |
| req_bar | input | 3 | BAR number the request hit |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken when high with rsp_valid |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | $clog2(NUM_REGIONS) | Matching region number |

## Verification
The hardest situation to reach is a result held under back-pressure while new requests queue behind it, with overlapping regions deciding the winner. To get there, the bench programs two address-match regions over the same window and a BAR region. It then streams hundreds of requests around the window edges while `rsp_ready` toggles pseudo-randomly. As a result, HOLD, REFILL and DRAIN occur at every boundary address. A behavioural model predicts each output on every clock.

// File: rtl/inb_xlate_pkg.sv
package inb_xlate_pkg;

    localparam int unsigned CFG_AW      = 3;
    localparam int unsigned BAR_W       = 3;
    localparam int unsigned TYPE_W      = 5;
    localparam int unsigned EN_BIT      = 31;
    localparam int unsigned BARMODE_BIT = 30;
    localparam int unsigned BARNUM_LSB  = 8;
    localparam logic [TYPE_W-1:0] TYPE_MEMORY = '0;

    typedef enum logic [CFG_AW-1:0] {
        REG_VIEWPORT = 3'd0,
        REG_TGT_LO   = 3'd1,
        REG_TGT_HI   = 3'd2,
        REG_TYPE     = 3'd3,
        REG_MODE     = 3'd4,
        REG_START_LO = 3'd5,
        REG_START_HI = 3'd6
    } cfg_reg_e;

    typedef struct packed {
        logic [63:0]       target;
        logic [63:0]       start;
        logic [TYPE_W-1:0] rtype;
        logic              enable;
        logic              bar_mode;
        logic [BAR_W-1:0]  bar_num;
    } region_cfg_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/inb_xlate_regfile.sv
module inb_xlate_regfile
    import inb_xlate_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output region_cfg_t       regions [NUM_REGIONS]
);
    localparam int unsigned VP_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [VP_W-1:0] viewport;
    logic            vp_write_ok;

    assign vp_write_ok = cfg_we && (cfg_addr == REG_VIEWPORT)
                         && (cfg_wdata < 32'(NUM_REGIONS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viewport <= '0;
        end else if (vp_write_ok) begin
            viewport <= cfg_wdata[VP_W-1:0];
        end
    end

    AST_VIEWPORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(viewport) < 32'(NUM_REGIONS)); // R2

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic sel;
        assign sel = cfg_we && (viewport == VP_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regions[g] <= '0;
            end else if (sel) begin
                unique case (cfg_reg_e'(cfg_addr))
                    REG_TGT_LO:   regions[g].target[31:0]  <= cfg_wdata;
                    REG_TGT_HI:   regions[g].target[63:32] <= cfg_wdata;
                    REG_TYPE:     regions[g].rtype         <= cfg_wdata[TYPE_W-1:0];
                    REG_MODE: begin
                        regions[g].enable   <= cfg_wdata[EN_BIT];
                        regions[g].bar_mode <= cfg_wdata[BARMODE_BIT];
                        regions[g].bar_num  <= cfg_wdata[BARNUM_LSB +: BAR_W];
                    end
                    REG_START_LO: regions[g].start[31:0]  <= cfg_wdata;
                    REG_START_HI: regions[g].start[63:32] <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/inb_xlate_match.sv
module inb_xlate_match
    import inb_xlate_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned NUM_BARS    = 6,
    parameter int unsigned WIN_BITS    = 24,
    parameter int unsigned RG_W        = 3
) (
    input  region_cfg_t          regions [NUM_REGIONS],
    input  logic [NUM_BARS*32-1:0] bar_mask,
    input  logic [63:0]          req_addr,
    input  logic [BAR_W-1:0]     req_bar,
    output logic [63:0]          xl_addr,
    output logic                 xl_hit,
    output logic [RG_W-1:0]      xl_region
);
    localparam int unsigned MASK_SLOTS = 1 << BAR_W;

    logic [31:0]            mask_arr [MASK_SLOTS];
    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] grant;
    logic [63:0]            cand [NUM_REGIONS];

    for (genvar b = 0; b < MASK_SLOTS; b++) begin : g_mask
        if (b < NUM_BARS) begin : g_real
            assign mask_arr[b] = bar_mask[32*b +: 32];
        end else begin : g_none
            assign mask_arr[b] = '1;
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [64:0] diff;
        logic [31:0] m;
        logic        usable;
        logic        bar_hit;
        logic        win_hit;

        assign usable  = regions[g].enable && (regions[g].rtype == TYPE_MEMORY);
        assign m       = mask_arr[regions[g].bar_num];
        assign diff    = {1'b0, req_addr} - {1'b0, regions[g].start};
        assign bar_hit = regions[g].bar_mode && (req_bar == regions[g].bar_num);
        assign win_hit = !regions[g].bar_mode && !diff[64] && (diff[63:WIN_BITS] == '0);

        assign hit_vec[g] = usable && (bar_hit || win_hit);
        assign cand[g]    = regions[g].bar_mode
            ? {regions[g].target[63:32], (regions[g].target[31:0] & m) | (req_addr[31:0] & ~m)}
            : regions[g].target + diff[63:0];
    end

    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int g = 0; g < NUM_REGIONS; g++) begin
            grant[g] = hit_vec[g] && !seen;
            seen     = seen || hit_vec[g];
        end
    end

    always_comb begin
        xl_addr   = req_addr;
        xl_hit    = 1'b0;
        xl_region = '0;
        for (int g = NUM_REGIONS - 1; g >= 0; g--) begin
            if (hit_vec[g]) begin
                xl_addr   = cand[g];
                xl_hit    = 1'b1;
                xl_region = RG_W'(g);
            end
        end
    end

    always_comb begin
        AST_ONE_WINNER: assert ($onehot0(grant)); // R6
        AST_WINNER_IS_LOWEST: assert (!xl_hit || grant[xl_region]); // R6
    end

endmodule

// File: rtl/inb_xlate_stage.sv
module inb_xlate_stage
    import inb_xlate_pkg::*;
#(
    parameter int unsigned RG_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     d_addr,
    input  logic            d_hit,
    input  logic [RG_W-1:0] d_region,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [63:0]     q_addr,
    output logic            q_hit,
    output logic [RG_W-1:0] q_region
);
    stage_state_e state, state_nxt;
    logic         load;

    assign load = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (req_valid)                state_nxt = ST_FULL;
            ST_FULL:  if (rsp_ready && !req_valid)  state_nxt = ST_EMPTY;
            default:                                state_nxt = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_EMPTY: begin rsp_valid = 1'b0; req_ready = 1'b1;      end
            ST_FULL:  begin rsp_valid = 1'b1; req_ready = rsp_ready; end
            default:  begin rsp_valid = 1'b0; req_ready = 1'b0;      end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr   <= '0;
            q_hit    <= 1'b0;
            q_region <= '0;
        end else if (load) begin
            q_addr   <= d_addr;
            q_hit    <= d_hit;
            q_region <= d_region;
        end
    end

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(q_addr) && $stable(q_hit) && $stable(q_region))); // R8
    AST_NO_ACCEPT_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R8

endmodule

// File: rtl/inb_xlate_unit.sv
module inb_xlate_unit
    import inb_xlate_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 5,
    parameter int unsigned NUM_BARS    = 6,
    parameter int unsigned WIN_BITS    = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [2:0]                     cfg_addr,
    input  logic [31:0]                    cfg_wdata,
    input  logic [NUM_BARS*32-1:0]         bar_mask,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [63:0]                    req_addr,
    input  logic [2:0]                     req_bar,
    output logic                           rsp_valid,
    input  logic                           rsp_ready,
    output logic [63:0]                    rsp_addr,
    output logic                           rsp_hit,
    output logic [$clog2(NUM_REGIONS)-1:0] rsp_region
);
    localparam int unsigned RG_W = $clog2(NUM_REGIONS);

    region_cfg_t     regions [NUM_REGIONS];
    logic [63:0]     xl_addr;
    logic            xl_hit;
    logic [RG_W-1:0] xl_region;

    inb_xlate_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .regions(regions)
    );

    inb_xlate_match #(
        .NUM_REGIONS(NUM_REGIONS), .NUM_BARS(NUM_BARS),
        .WIN_BITS(WIN_BITS), .RG_W(RG_W)
    ) u_match (
        .regions(regions), .bar_mask(bar_mask), .req_addr(req_addr),
        .req_bar(req_bar), .xl_addr(xl_addr), .xl_hit(xl_hit), .xl_region(xl_region)
    );

    inb_xlate_stage #(.RG_W(RG_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .d_addr(xl_addr), .d_hit(xl_hit), .d_region(xl_region),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .q_addr(rsp_addr), .q_hit(rsp_hit), .q_region(rsp_region)
    );

    AST_MISS_REGION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_region == '0)); // R7
    AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (32'(rsp_region) < 32'(NUM_REGIONS))); // R6
    AST_PASS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl_hit) |=> (rsp_addr == $past(req_addr))); // R7

endmodule

// File: tb/inb_xlate_unit_bench.sv
`timescale 1ns/1ps
module inb_xlate_unit_bench;
    localparam int NR = 5;
    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NB*32-1:0] bar_mask;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [63:0]   req_addr = '0;
    logic [2:0]    req_bar = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [63:0]   rsp_addr;
    logic          rsp_hit;
    logic [2:0]    rsp_region;

    always #4 clk = ~clk;

    inb_xlate_unit u_inb_xlate_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bar_mask(bar_mask), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_bar(req_bar),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_hit(rsp_hit), .rsp_region(rsp_region)
    );

    logic [31:0] bmask [NB];
    initial begin
        bmask[0] = 32'hFFFF_0000; bmask[1] = 32'hFFF0_0000; bmask[2] = 32'hFF00_0000;
        bmask[3] = 32'hFFFF_F000; bmask[4] = 32'hF000_0000; bmask[5] = 32'hFFFF_FF00;
    end
    always_comb for (int b = 0; b < NB; b++) bar_mask[32*b +: 32] = bmask[b];

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    bit    stall_on = 1'b0;
    bit    done     = 1'b0;

    // behavioural reference model
    logic [63:0] m_tgt [NR];
    logic [63:0] m_st  [NR];
    logic [4:0]  m_typ [NR];
    bit          m_en  [NR];
    bit          m_bm  [NR];
    int          m_bn  [NR];
    int          m_vp;
    bit          exp_v;
    logic [63:0] exp_addr;
    bit          exp_hit;
    int          exp_reg;

    task automatic model_xlate(input logic [63:0] a, input int b,
                               output logic [63:0] o, output bit h, output int r);
        o = a; h = 0; r = 0;
        for (int i = 0; i < NR; i++) begin
            if (!h && m_en[i] && m_typ[i] == 0) begin
                if (m_bm[i]) begin
                    if (b == m_bn[i]) begin
                        logic [31:0] mk;
                        mk = (m_bn[i] < NB) ? bmask[m_bn[i]] : 32'hFFFF_FFFF;
                        o = {m_tgt[i][63:32], (m_tgt[i][31:0] & mk) | (a[31:0] & ~mk)};
                        h = 1; r = i;
                    end
                end else if (a >= m_st[i] && (a - m_st[i]) <= 64'hFF_FFFF) begin
                    o = m_tgt[i] + (a - m_st[i]);
                    h = 1; r = i;
                end
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_v = 0; m_vp = 0;
            for (int i = 0; i < NR; i++) begin
                m_tgt[i] = 0; m_st[i] = 0; m_typ[i] = 0; m_en[i] = 0; m_bm[i] = 0; m_bn[i] = 0;
            end
        end else begin
            if (req_valid && (!exp_v || rsp_ready)) begin
                model_xlate(req_addr, int'(req_bar), exp_addr, exp_hit, exp_reg);
                exp_v = 1;
            end else if (rsp_ready) begin
                exp_v = 0;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: if (cfg_wdata < NR) m_vp = int'(cfg_wdata);
                    3'd1: m_tgt[m_vp][31:0]  = cfg_wdata;
                    3'd2: m_tgt[m_vp][63:32] = cfg_wdata;
                    3'd3: m_typ[m_vp] = cfg_wdata[4:0];
                    3'd4: begin
                        m_en[m_vp] = cfg_wdata[31];
                        m_bm[m_vp] = cfg_wdata[30];
                        m_bn[m_vp] = int'(cfg_wdata[10:8]);
                    end
                    3'd5: m_st[m_vp][31:0]  = cfg_wdata;
                    3'd6: m_st[m_vp][63:32] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // compare against the model every cycle (R8 handshake, payload per phase tag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("rsp_valid", 64'(rsp_valid), 64'(exp_v));
            chk("req_ready", 64'(req_ready), 64'(!exp_v || rsp_ready));
            if (exp_v) begin
                chk("rsp_addr", rsp_addr, exp_addr);
                chk("rsp_hit", 64'(rsp_hit), 64'(exp_hit));
                chk("rsp_region", 64'(rsp_region), 64'(exp_reg));
            end
        end
    end

    always @(posedge clk) begin
        #1;
        rsp_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(input logic [63:0] a, input int b);
        bit rdy;
        req_valid = 1; req_addr = a; req_bar = 3'(b);
        do begin
            rdy = req_ready;
            @(negedge clk);
        end while (!rdy);
    endtask

    task automatic idle(input int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    localparam logic [63:0] WSTART = 64'h0000_0012_3400_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 reset actual v=%b r=%b expected v=0 r=1", rsp_valid, req_ready);
        end
        rst_n = 1;
        @(negedge clk);
        cur_tag = "R1";
        send(64'h0000_0001_1234_5678, 4); send(WSTART, 0); idle(3);

        // R2: out-of-range viewport ignored, writes land in region 0
        cur_tag = "R2";
        wr(0, 0); wr(0, 7);
        wr(1, 32'h8000_0000); wr(2, 0); wr(3, 0);
        wr(4, 32'hC000_0400);            // R3: enable, BAR mode, BAR 4
        @(negedge clk);
        send(64'h0000_0001_1234_5678, 4); idle(3);

        // R4: BAR match with two masks, and a miss on another BAR (R7)
        cur_tag = "R4";
        wr(0, 4); wr(1, 32'h4567_0000); wr(2, 32'h0000_ABCD); wr(3, 0); wr(4, 32'hC000_0000);
        @(negedge clk);
        send(64'h9999_0000_0000_1234, 0);
        send(64'h0000_0000_0FFF_FFFF, 4);
        cur_tag = "R7";
        send(64'h0000_0000_DEAD_BEEF, 2);
        idle(3);

        // R5: address window edges
        cur_tag = "R5";
        wr(0, 2); wr(5, WSTART[31:0]); wr(6, WSTART[63:32]);
        wr(1, 32'h8000_0000); wr(2, 0); wr(3, 0); wr(4, 32'h8000_0000);
        @(negedge clk);
        send(WSTART, 1); send(WSTART + 64'hFF_FFFF, 1);
        send(WSTART + 64'h100_0000, 1); send(WSTART - 1, 1);
        idle(3);

        // R6: overlapping region 1 wins over region 2
        cur_tag = "R6";
        wr(0, 1); wr(5, WSTART[31:0]); wr(6, WSTART[63:32]);
        wr(1, 32'h9000_0000); wr(2, 0); wr(3, 0); wr(4, 32'h8000_0000);
        @(negedge clk);
        send(WSTART + 64'h10, 3); idle(3);

        // R9: disabled region and non-memory type never hit
        cur_tag = "R9";
        wr(0, 1); wr(4, 32'h0000_0000);
        wr(0, 3); wr(1, 32'h1000_0000); wr(3, 2); wr(4, 32'hC000_0100);
        @(negedge clk);
        send(WSTART + 64'h10, 3); send(64'h0000_0000_0012_3456, 1); idle(3);
        cur_tag = "R3";
        wr(0, 1); wr(4, 32'h8000_0000);  // re-enable region 1 in address mode
        @(negedge clk);
        send(WSTART + 64'h20, 5); idle(3);

        // R8: streaming under back-pressure across boundaries
        cur_tag = "R8";
        stall_on = 1;
        for (int k = 0; k < 400; k++) begin
            logic [63:0] a;
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0)      a = {$urandom, $urandom};
            else if (sel == 1) a = WSTART + 64'(($urandom % 32'h200_0000)) - 64'h80_0000;
            else if (sel == 2) a = WSTART + 64'hFF_FFFF + 64'($urandom % 3) - 1;
            else               a = {32'h0, $urandom};
            send(a, int'($urandom % 6));
            if (($urandom % 5) == 0) idle(int'($urandom % 3));
        end
        idle(10);
        stall_on = 0;
        idle(5);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired in phase %s actual=running expected=finished", cur_tag);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule